// File: doc/BRIEF.md
# Bundle Template Decoder

This block sits between an instruction fetch buffer and an issue stage. Each fetched word is a 128-bit bundle: a 5-bit template in bits 4:0 and three 41-bit instruction slots above it. The block does not look inside the instructions. From the template alone it works out three things. First, the functional-unit class each slot needs. Second, which slots hold a real operation: in the long-immediate form, two slots carry one operation. Third, where the stops fall. A stop closes a parallel issue group.

Bundles arrive on a valid/ready stream and leave on another one, through a single registered stage. Every slot is tagged with a group number taken from a running counter. The counter advances once per stop. An issue stage can therefore collect a group that began in an earlier bundle. Unused template codes are flagged as illegal, and no slot of such a bundle is marked valid.

Top module: `bundle_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the group counter starts at 0. The first legal bundle accepted therefore tags its slot 0 with group 0.
- R2: Unit classes are encoded as M=0, I=1, F=2, B=3, with slot k's class at `out_slot_unit[2k+1:2k]`. Slot 0 is the lowest slot.
  - For template codes 0 to 19, the slot order is index code/2 into this list: MII, MMI, MFI, MIB, MMB, MFB, MMF, MBB, BBB, MLX.
  - For codes 20 to 25, the slot order is MII (codes 20 and 21), MMI (codes 22 and 23) or MFI (codes 24 and 25).
  - Every slot of a legal non-long bundle is valid.
- R3: For the long-immediate order (codes 18 and 19):
  - slot 0 is M;
  - slot 1 carries the combined operation with class I;
  - slot 2 is not valid;
  - `out_long_imm` is 1.
- R4: For codes 0 to 25, an odd code puts an end-of-group flag on the last valid slot: slot 2, or slot 1 in the long form. An even code puts no flag there.
- R5: Codes 20 and 21 add a stop after slot 0. Codes 22 to 25 add a stop after slot 1.
- R6: Codes 26 to 31 are illegal. The bundle still passes through with `out_illegal`=1, all slot valid and end flags 0, and the group counter unchanged.
- R7: Slot k's group is the counter value plus the number of stops on slots below k. On acceptance, the counter advances by the number of stops in the bundle, modulo 2^GRP_W.
- R8: `in_ready` is 1 when the output register is empty or the output is being taken. Output is held unchanged while `out_valid` is 1 and `out_ready` is 0.
- R9: `out_slot_word` slot k equals input bits [5+41k+40 : 5+41k], passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle taken this cycle when valid |
| in_bundle | input | 128 | Template plus three slots |
| out_valid | output | 1 | Decoded bundle available |
| out_ready | input | 1 | Consumer takes the decoded bundle |
| out_illegal | output | 1 | Template code unused |
| out_long_imm | output | 1 | Slots 1 and 2 form one operation |
| out_slot_valid | output | 3 | Slot holds an operation |
| out_slot_unit | output | 6 | Unit class per slot, 2 bits each |
| out_slot_end | output | 3 | Slot closes its issue group |
| out_slot_group | output | 24 | Group number per slot, GRP_W bits each |
| out_slot_word | output | 123 | Raw slot contents, 41 bits each |

## Verification
The hardest case to reach is a group counter that has wrapped several times while bundles are stalled. The counter state then depends on every stop ever accepted. It also depends on whether an acceptance coincided with a held output.

The stimulus first walks through all 32 template codes, then runs several thousand cycles. In those cycles, input validity, template choice and output readiness are all drawn at random, with long stretches of back-pressure. The bench reference model carries the counter across the whole run. The counter therefore wraps many times, and it is compared on every stalled and moving cycle.

// File: rtl/bdec_pkg.sv
// Shared definitions for the bundle decoder.
// Holds the unit-class encoding, the fixed bundle geometry, and the
// legal slot orders indexed by template code / 2.
package bdec_pkg;

    typedef enum logic [1:0] {
        UNIT_M = 2'd0,
        UNIT_I = 2'd1,
        UNIT_F = 2'd2,
        UNIT_B = 2'd3
    } unit_e;

    localparam int NSLOT      = 3;
    localparam int TMPL_W     = 5;
    localparam int UNIT_W     = 2;
    localparam int NORDER     = 10;
    localparam int LONG_ORDER = 9;
    localparam logic [TMPL_W-1:0] FIRST_MID = 5'd20;
    localparam logic [TMPL_W-1:0] FIRST_BAD = 5'd26;

    // Slot classes of one order; slot 0 sits in the low bits.
    function automatic logic [NSLOT*UNIT_W-1:0] order_units(input logic [3:0] ord);
        logic [NSLOT*UNIT_W-1:0] u;
        case (ord)
            4'd0:    u = {UNIT_I, UNIT_I, UNIT_M};
            4'd1:    u = {UNIT_I, UNIT_M, UNIT_M};
            4'd2:    u = {UNIT_I, UNIT_F, UNIT_M};
            4'd3:    u = {UNIT_B, UNIT_I, UNIT_M};
            4'd4:    u = {UNIT_B, UNIT_M, UNIT_M};
            4'd5:    u = {UNIT_B, UNIT_F, UNIT_M};
            4'd6:    u = {UNIT_F, UNIT_M, UNIT_M};
            4'd7:    u = {UNIT_B, UNIT_B, UNIT_M};
            4'd8:    u = {UNIT_B, UNIT_B, UNIT_B};
            4'd9:    u = {UNIT_M, UNIT_I, UNIT_M};
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/bdec_tmpl_decode.sv
// Template decoder: purely combinational.
// Maps the 5-bit template to slot classes, slot validity, stop flags,
// the long-immediate flag and legality.
// Assumes codes 0..19 are order*2+endstop, 20..25 are the mid-stop
// variants, and 26..31 are unused.
module bdec_tmpl_decode
    import bdec_pkg::*;
(
    input  logic [TMPL_W-1:0]       tmpl,
    output logic                    legal,
    output logic                    long_imm,
    output logic [NSLOT-1:0]        slot_vld,
    output logic [NSLOT*UNIT_W-1:0] slot_unit,
    output logic [NSLOT-1:0]        slot_end
);

    logic [3:0] ord;
    logic       mid_form;
    logic [1:0] mid_sel;

    // Pick the order index and mid-stop variant from the code.
    always_comb begin
        mid_form = (tmpl >= FIRST_MID) && (tmpl < FIRST_BAD);
        mid_sel  = 2'((tmpl - FIRST_MID) >> 1);
        if (mid_form) begin
            ord = 4'(mid_sel);
        end else begin
            ord = tmpl[4:1];
        end
    end

    // Build the per-slot outputs for legal codes, zeros otherwise.
    always_comb begin
        legal     = (tmpl < FIRST_BAD);
        long_imm  = legal && !mid_form && (ord == 4'(LONG_ORDER));
        slot_vld  = '0;
        slot_unit = '0;
        slot_end  = '0;
        if (legal) begin
            slot_unit = order_units(ord);
            slot_vld  = long_imm ? 3'b011 : 3'b111;
            if (long_imm) begin
                slot_unit[2*UNIT_W +: UNIT_W] = UNIT_M;
            end
            if (mid_form) begin
                if (mid_sel == 2'd0) begin
                    slot_end[0] = 1'b1;
                end else begin
                    slot_end[1] = 1'b1;
                end
            end
            if (tmpl[0]) begin
                if (long_imm) begin
                    slot_end[1] = 1'b1;
                end else begin
                    slot_end[NSLOT-1] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bdec_group_tag.sv
// Group tagger: adds to the running base the count of stops on lower
// slots, giving each slot its group number, and reports the bundle's
// total stop count.
// Assumes stop flags are only set on valid slots.
module bdec_group_tag
    import bdec_pkg::*;
#(
    parameter int GRP_W = 8
) (
    input  logic [GRP_W-1:0]       base,
    input  logic [NSLOT-1:0]       slot_end,
    output logic [NSLOT*GRP_W-1:0] slot_grp,
    output logic [1:0]             stop_cnt
);

    localparam int CNT_W = 2;

    logic [CNT_W-1:0] prefix [NSLOT+1];

    // Running count of stops strictly below each slot.
    always_comb begin
        prefix[0] = '0;
        for (int k = 0; k < NSLOT; k++) begin
            prefix[k+1] = prefix[k] + CNT_W'(slot_end[k]);
        end
    end

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_tag
            // Group number of slot g.
            assign slot_grp[g*GRP_W +: GRP_W] = base + GRP_W'(prefix[g]);
        end
    endgenerate

    assign stop_cnt = prefix[NSLOT];

endmodule

// File: rtl/bdec_out_stage.sv
// One-entry output register with a valid/ready handshake.
// Accepts new data whenever it is empty or being drained, and holds its
// data while stalled.
module bdec_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic         vld_q;
    logic [W-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    // Load on acceptance, clear when drained with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (in_ready) begin
            vld_q <= in_valid;
            if (in_valid) begin
                dat_q <= in_data;
            end
        end
    end

endmodule

// File: rtl/bundle_decoder.sv
// Bundle decoder top.
// Splits each bundle into template and slots, decodes the template,
// tags slots with issue-group numbers from a running counter, and
// registers the result behind a valid/ready stage.
// Assumes the template sits in the low bits, with slots packed above it.
module bundle_decoder
    import bdec_pkg::*;
#(
    parameter int SLOT_W = 41,
    parameter int GRP_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [TMPL_W+NSLOT*SLOT_W-1:0] in_bundle,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic                       out_illegal,
    output logic                       out_long_imm,
    output logic [NSLOT-1:0]           out_slot_valid,
    output logic [NSLOT*UNIT_W-1:0]    out_slot_unit,
    output logic [NSLOT-1:0]           out_slot_end,
    output logic [NSLOT*GRP_W-1:0]     out_slot_group,
    output logic [NSLOT*SLOT_W-1:0]    out_slot_word
);

    localparam int PAY_W = 2 + 2*NSLOT + NSLOT*UNIT_W + NSLOT*GRP_W + NSLOT*SLOT_W;

    logic                    legal;
    logic                    long_imm;
    logic [NSLOT-1:0]        slot_vld;
    logic [NSLOT*UNIT_W-1:0] slot_unit;
    logic [NSLOT-1:0]        slot_end;
    logic [NSLOT*GRP_W-1:0]  slot_grp;
    logic [1:0]              stop_cnt;
    logic [GRP_W-1:0]        base_q;
    logic [PAY_W-1:0]        pay_d;
    logic [PAY_W-1:0]        pay_q;
    logic                    accept;

    bdec_tmpl_decode u_dec (
        .tmpl      (in_bundle[TMPL_W-1:0]),
        .legal     (legal),
        .long_imm  (long_imm),
        .slot_vld  (slot_vld),
        .slot_unit (slot_unit),
        .slot_end  (slot_end)
    );

    bdec_group_tag #(.GRP_W(GRP_W)) u_tag (
        .base     (base_q),
        .slot_end (slot_end),
        .slot_grp (slot_grp),
        .stop_cnt (stop_cnt)
    );

    assign accept = in_valid && in_ready;

    // Advance the group counter by the stops of each accepted bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (accept) begin
            base_q <= base_q + GRP_W'(stop_cnt);
        end
    end

    // Gather decoded fields and raw slot words into one payload.
    assign pay_d = {!legal, long_imm, slot_vld, slot_unit, slot_end, slot_grp,
                    in_bundle[TMPL_W +: NSLOT*SLOT_W]};

    bdec_out_stage #(.W(PAY_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (pay_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (pay_q)
    );

    assign {out_illegal, out_long_imm, out_slot_valid, out_slot_unit, out_slot_end,
            out_slot_group, out_slot_word} = pay_q;

endmodule

// File: rtl/bundle_decoder_chk.sv
// Assertion checker for bundle_decoder, attached by bind.
// Observes ports only.
module bundle_decoder_chk
    import bdec_pkg::*;
#(
    parameter int SLOT_W = 41,
    parameter int GRP_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    out_illegal,
    input logic                    out_long_imm,
    input logic [NSLOT-1:0]        out_slot_valid,
    input logic [NSLOT*UNIT_W-1:0] out_slot_unit,
    input logic [NSLOT-1:0]        out_slot_end,
    input logic [NSLOT*GRP_W-1:0]  out_slot_group,
    input logic [NSLOT*SLOT_W-1:0] out_slot_word
);

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_word)
                                       && $stable(out_slot_group) && $stable(out_slot_unit)));

    a_r6_illegal_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_slot_valid == '0 && out_slot_end == '0));

    a_r3_long_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_long_imm) |-> (out_slot_valid == 3'b011
                                         && out_slot_unit[2 +: 2] == UNIT_I));

    a_r4_end_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_slot_end & ~out_slot_valid) == '0));

    a_r7_group_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_slot_valid[1]) |->
        (out_slot_group[GRP_W +: GRP_W] == out_slot_group[0 +: GRP_W] + GRP_W'(out_slot_end[0])));

endmodule

bind bundle_decoder bundle_decoder_chk #(.SLOT_W(SLOT_W), .GRP_W(GRP_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_illegal    (out_illegal),
    .out_long_imm   (out_long_imm),
    .out_slot_valid (out_slot_valid),
    .out_slot_unit  (out_slot_unit),
    .out_slot_end   (out_slot_end),
    .out_slot_group (out_slot_group),
    .out_slot_word  (out_slot_word)
);

// File: tb/bundle_decoder_tb_top.sv
`timescale 1ns/1ps
module bundle_decoder_tb_top;

    localparam int SW = 41;
    localparam int GW = 8;
    localparam int BW = 5 + 3*SW;
    localparam int NCYC = 6000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [BW-1:0]   in_bundle;
    logic            out_valid;
    logic            out_ready;
    logic            out_illegal;
    logic            out_long_imm;
    logic [2:0]      out_slot_valid;
    logic [5:0]      out_slot_unit;
    logic [2:0]      out_slot_end;
    logic [3*GW-1:0] out_slot_group;
    logic [3*SW-1:0] out_slot_word;

    always #2 clk = ~clk;

    bundle_decoder #(.SLOT_W(SW), .GRP_W(GW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
        .out_illegal(out_illegal), .out_long_imm(out_long_imm),
        .out_slot_valid(out_slot_valid), .out_slot_unit(out_slot_unit),
        .out_slot_end(out_slot_end), .out_slot_group(out_slot_group),
        .out_slot_word(out_slot_word)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    string ORD [10] = '{"MII", "MMI", "MFI", "MIB", "MMB", "MFB", "MMF", "MBB", "BBB", "MLX"};
    string MORD [3] = '{"MII", "MMI", "MFI"};

    // Reference model state: one held entry plus the group counter.
    bit          mv;
    bit [4:0]    m_tmpl;
    bit          m_il, m_long;
    bit [2:0]    m_vld, m_end;
    bit [5:0]    m_unit;
    bit [GW-1:0] m_grp [3];
    bit [SW-1:0] m_word [3];
    int          m_base;
    bit          m_rdy;

    function automatic bit [1:0] unit_of(input byte c);
        case (c)
            "M": return 2'd0;
            "I": return 2'd1;
            "F": return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    task automatic model_load(input logic [BW-1:0] b);
        string s;
        int    mid;
        int    cnt;
        m_tmpl = b[4:0];
        m_il = 0; m_long = 0; m_vld = 0; m_end = 0; m_unit = 0;
        if (m_tmpl >= 26) begin
            m_il = 1;
        end else begin
            if (m_tmpl < 20) begin
                s = ORD[m_tmpl / 2];
                mid = -1;
            end else begin
                s = MORD[(m_tmpl - 20) / 2];
                mid = (m_tmpl < 22) ? 0 : 1;
            end
            if (s == "MLX") begin
                m_long = 1; m_vld = 3'b011; m_unit = 6'b00_01_00;
            end else begin
                m_vld = 3'b111;
                for (int k = 0; k < 3; k++) m_unit[2*k +: 2] = unit_of(s[k]);
            end
            if (mid >= 0) m_end[mid] = 1;
            if (m_tmpl[0]) m_end[m_long ? 1 : 2] = 1;
        end
        cnt = 0;
        for (int k = 0; k < 3; k++) begin
            m_grp[k] = GW'(m_base + cnt);
            if (m_end[k]) cnt++;
            m_word[k] = b[5 + k*SW +: SW];
        end
        m_base = (m_base + cnt) % (1 << GW);
    endtask

    // Model advance on each rising edge, with inputs stable since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mv = 0;
            m_base = 0;
        end else begin
            m_rdy = !mv || out_ready;
            if (in_valid && m_rdy) begin
                model_load(in_bundle);
                mv = 1;
            end else if (mv && out_ready) begin
                mv = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(input int cyc);
        string rq;
        rq = (cyc == 0) ? "R1" : "R8";
        chk(out_valid == mv, rq, "out_valid", 128'(out_valid), 128'(mv));
        chk(in_ready == (!mv || out_ready), rq, "in_ready", 128'(in_ready), 128'(!mv || out_ready));
        if (mv && out_valid) begin
            chk(out_illegal == m_il, "R6", "illegal", 128'(out_illegal), 128'(m_il));
            chk(out_long_imm == m_long, "R3", "long_imm", 128'(out_long_imm), 128'(m_long));
            chk(out_slot_valid == m_vld, m_il ? "R6" : "R2", "slot_valid",
                128'(out_slot_valid), 128'(m_vld));
            chk(out_slot_end == m_end, (m_tmpl < 20 || m_tmpl >= 26) ? "R4" : "R5", "slot_end",
                128'(out_slot_end), 128'(m_end));
            for (int k = 0; k < 3; k++) begin
                if (m_vld[k]) begin
                    chk(out_slot_unit[2*k +: 2] == m_unit[2*k +: 2], m_long ? "R3" : "R2", "unit",
                        128'(out_slot_unit[2*k +: 2]), 128'(m_unit[2*k +: 2]));
                    chk(out_slot_group[k*GW +: GW] == m_grp[k], "R7", "group",
                        128'(out_slot_group[k*GW +: GW]), 128'(m_grp[k]));
                end
                chk(out_slot_word[k*SW +: SW] == m_word[k], "R9", "word",
                    128'(out_slot_word[k*SW +: SW]), 128'(m_word[k]));
            end
        end
    endtask

    // Stimulus: directed sweep of all codes, then random traffic with stalls.
    initial begin
        rst_n = 0; in_valid = 0; out_ready = 0; in_bundle = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            compare(cyc);
            if (cyc < 40) begin
                in_valid  = (cyc < 32);
                out_ready = 1;
                in_bundle = {$urandom, $urandom, $urandom, $urandom};
                in_bundle[4:0] = 5'(cyc);
            end else begin
                in_valid  = ($urandom % 10) < 7;
                if ((cyc / 200) % 3 == 1) out_ready = ($urandom % 10) < 2;
                else                      out_ready = ($urandom % 10) < 8;
                in_bundle = {$urandom, $urandom, $urandom, $urandom};
                if ($urandom % 4 == 0) in_bundle[4:0] = 5'd26 + 5'($urandom % 6);
                else                   in_bundle[4:0] = 5'($urandom % 26);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule